// File: doc/BRIEF.md
# Dual-Bank Byte Memory Port

This block sits between a processor-side request port and a byte-addressed memory. The memory is built either as two byte-wide banks behind a 16-bit data path or as one byte-wide bank behind an 8-bit data path. The `bus8_mode` input selects between the two. The processor issues byte or word reads and writes at any 20-bit byte address. The port works out how many memory bus cycles the access needs and raises the bank enables for each cycle. It moves every byte onto the correct data lane and reports completion with a one-clock done pulse.

In the 16-bit organisation, the even bank holds bytes at even addresses and uses the low data lane. The odd bank holds bytes at odd addresses and uses the high data lane. A word whose address is even is moved in one cycle. A word whose address is odd is broken into two byte cycles, and so is every word in the 8-bit organisation. In a split word, the low-order byte goes first at the request address and the high-order byte second at the following address. Each bus cycle lasts a fixed number of clocks, set by a parameter.

Top module: `byte_bank_port`

## Requirements
- R1: After reset, `port_idle` is 1, while `rsp_done`, `mem_en_even`, `mem_en_odd` and `mem_we` are all 0.
- R2: In 16-bit mode, a word at an even address uses one bus cycle with both bank enables high. The low-order byte goes to that address on `mem_wdata[7:0]` and the high-order byte goes to the next address on `mem_wdata[15:8]`. `rsp_done` rises WAIT_CYCLES+1 clocks after the request is accepted.
- R3: In 16-bit mode, a word at an odd address A uses two bus cycles and never enables both banks at once. The first cycle, at A on the odd bank, carries the low-order byte. The second cycle, at A+1 on the even bank, carries the high-order byte. `rsp_done` rises 2*(WAIT_CYCLES+1) clocks after acceptance.
- R4: In 16-bit mode, a byte access at an even address enables only `mem_en_even`. Its data uses lane `[7:0]`.
- R5: In 16-bit mode, a byte access at an odd address enables only `mem_en_odd`. Its data uses lane `[15:8]`. It is taken from `req_wdata[7:0]` and returned in `rsp_rdata[7:0]`. For every byte read, `rsp_rdata[15:8]` is 0.
- R6: In 8-bit mode (`bus8_mode`=1), every word access uses two bus cycles, whether its address is even or odd. Only `mem_en_even` is used, with data on lane `[7:0]`. The low-order byte is at A and the high-order byte at A+1.
- R7: In 8-bit mode, a byte access uses one bus cycle on `mem_en_even`, lane `[7:0]`. `rsp_done` rises WAIT_CYCLES+1 clocks after acceptance.
- R8: The second-cycle address is A+1 modulo 2^20, so a word at 0xFFFFF ends at address 0x00000.
- R9: `rsp_done` is high for exactly one clock, in the clock after the last bus cycle ends. `rsp_rdata` holds the complete read result while `rsp_done` is high.
- R10: A request is accepted only while `port_idle` is 1. A `req_valid` raised during an access is ignored and produces no memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus8_mode | input | 1 | 1 selects the single 8-bit bank, 0 selects the two 8-bit banks |
| req_valid | input | 1 | Request strobe; accepted only while idle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_word | input | 1 | 1 for a word, 0 for a byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data; a byte uses bits [7:0] |
| port_idle | output | 1 | Port can accept a request |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| mem_addr | output | 20 | Byte address of the current bus cycle |
| mem_en_even | output | 1 | Even bank enable; the only enable in 8-bit mode |
| mem_en_odd | output | 1 | Odd bank enable |
| mem_we | output | 1 | Write strobe for the enabled bank(s) |
| mem_wdata | output | 16 | Memory write data lanes |
| mem_rdata | input | 16 | Memory read data lanes |

## Verification
The bench aims at the alignment corners. An odd word in 16-bit mode must be split into two cycles with the low-order byte first. A design that treats it as aligned would write both bytes into the wrong word. A design that reverses the byte order would swap the bytes in memory. Odd-address bytes must cross from the high lane to the low byte of the result. Missing steering would place data in the wrong bank or return it in the upper byte. The bench also covers word accesses in 8-bit mode at even addresses, where a design that skips the second cycle would be seen to lose the high byte. It covers the wrap from 0xFFFFF to 0x00000, and a request raised mid-access, which a careless design would start as a second memory cycle.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic        mode8;
    logic        write;
    logic        word;
  } bbp_kind_t;
endpackage

// File: rtl/bbp_plan.sv
module bbp_plan #(
  parameter int unsigned AW = 20
) (
  input  logic          mode8,
  input  logic          is_word,
  input  logic [AW-1:0] base_addr,
  input  logic          phase,
  output logic          two_cycle,
  output logic          full_word,
  output logic [AW-1:0] cyc_addr,
  output logic          sel_even,
  output logic          sel_odd,
  output logic          lane_hi
);
  always_comb begin
    two_cycle = is_word && (mode8 || base_addr[0]);
    full_word = is_word && !mode8 && !base_addr[0];
    cyc_addr  = phase ? (base_addr + AW'(1)) : base_addr;
    if (mode8) begin
      sel_even = 1'b1;
      sel_odd  = 1'b0;
      lane_hi  = 1'b0;
    end else if (full_word) begin
      sel_even = 1'b1;
      sel_odd  = 1'b1;
      lane_hi  = 1'b0;
    end else begin
      sel_even = !cyc_addr[0];
      sel_odd  = cyc_addr[0];
      lane_hi  = cyc_addr[0];
    end
  end
endmodule

// File: rtl/bbp_seq.sv
module bbp_seq #(
  parameter int unsigned WAIT_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic two_cycle,
  output logic active,
  output logic phase,
  output logic cyc_end,
  output logic done
);
  localparam int unsigned WCW = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
  localparam logic [WCW-1:0] WLAST = WCW'(WAIT_CYCLES);

  logic           active_q, active_d;
  logic           phase_q, phase_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic           done_q, done_d;

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    wcnt_d   = wcnt_q;
    cyc_end  = active_q && (wcnt_q == WLAST);
    done_d   = cyc_end && (!two_cycle || phase_q);
    if (!active_q) begin
      if (start) begin
        active_d = 1'b1;
        phase_d  = 1'b0;
        wcnt_d   = '0;
      end
    end else if (cyc_end) begin
      wcnt_d = '0;
      if (two_cycle && !phase_q) phase_d = 1'b1;
      else active_d = 1'b0;
    end else begin
      wcnt_d = wcnt_q + WCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      wcnt_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      wcnt_q   <= wcnt_d;
      done_q   <= done_d;
    end
  end

  assign active = active_q;
  assign phase  = phase_q;
  assign done   = done_q;
endmodule

// File: rtl/bbp_steer.sv
module bbp_steer #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          capture,
  input  logic          full_word,
  input  logic          lane_hi,
  input  logic          byte_hi,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] cpu_rdata
);
  localparam int unsigned BW = bbp_pkg::BYTE_W;

  logic [BW-1:0] wbyte, rbyte;
  logic [DW-1:0] rd_q, rd_d;
  logic          rd_en;

  always_comb begin
    wbyte = byte_hi ? cpu_wdata[DW-1:BW] : cpu_wdata[BW-1:0];
    if (full_word)    mem_wdata = cpu_wdata;
    else if (lane_hi) mem_wdata = {wbyte, {BW{1'b0}}};
    else              mem_wdata = {{BW{1'b0}}, wbyte};
    rbyte = lane_hi ? mem_rdata[DW-1:BW] : mem_rdata[BW-1:0];
  end

  always_comb begin
    rd_en = clear || capture;
    rd_d  = rd_q;
    if (clear) rd_d = '0;
    else if (capture) begin
      if (full_word)    rd_d = mem_rdata;
      else if (byte_hi) rd_d[DW-1:BW] = rbyte;
      else              rd_d[BW-1:0] = rbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign cpu_rdata = rd_q;
endmodule

// File: rtl/byte_bank_port.sv
module byte_bank_port #(
  parameter int unsigned AW          = 20,
  parameter int unsigned DW          = 16,
  parameter int unsigned WAIT_CYCLES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus8_mode,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          port_idle,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en_even,
  output logic          mem_en_odd,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import bbp_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bbp_kind_t     kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          start, active, phase, cyc_end, done;
  logic          two_cycle, full_word, sel_even, sel_odd, lane_hi;
  logic [AW-1:0] cyc_addr;

  assign start = req_valid && !active;

  always_comb begin
    kind_d  = kind_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (start) begin
      kind_d  = '{mode8: bus8_mode, write: req_write, word: req_word};
      addr_d  = req_addr;
      wdata_d = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  bbp_plan #(.AW(AW)) u_plan (
    .mode8     (kind_q.mode8),
    .is_word   (kind_q.word),
    .base_addr (addr_q),
    .phase     (phase),
    .two_cycle (two_cycle),
    .full_word (full_word),
    .cyc_addr  (cyc_addr),
    .sel_even  (sel_even),
    .sel_odd   (sel_odd),
    .lane_hi   (lane_hi)
  );

  bbp_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .two_cycle (two_cycle),
    .active    (active),
    .phase     (phase),
    .cyc_end   (cyc_end),
    .done      (done)
  );

  bbp_steer #(.DW(DW)) u_steer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear     (start),
    .capture   (cyc_end && !kind_q.write),
    .full_word (full_word),
    .lane_hi   (lane_hi),
    .byte_hi   (phase),
    .cpu_wdata (wdata_q),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .cpu_rdata (rsp_rdata)
  );

  assign port_idle   = !active;
  assign rsp_done    = done;
  assign mem_addr    = active ? cyc_addr : '0;
  assign mem_en_even = active && sel_even;
  assign mem_en_odd  = active && sel_odd;
  assign mem_we      = active && kind_q.write;
endmodule

// File: rtl/byte_bank_port_checker.sv
module byte_bank_port_checker #(
  parameter int unsigned AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          port_idle,
  input logic          rsp_done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_en_even,
  input logic          mem_en_odd,
  input logic          mem_we
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    port_idle |-> (!mem_en_even && !mem_en_odd && !mem_we));

  a_r2_dual_only_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_even && mem_en_odd) |-> !mem_addr[0]);

  a_r9_done_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r9_done_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($past(mem_en_even || mem_en_odd) && port_idle));

  a_r10_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
    (port_idle && !req_valid) |=> port_idle);
endmodule

bind byte_bank_port byte_bank_port_checker #(.AW(AW)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .port_idle   (port_idle),
  .rsp_done    (rsp_done),
  .mem_addr    (mem_addr),
  .mem_en_even (mem_en_even),
  .mem_en_odd  (mem_en_odd),
  .mem_we      (mem_we)
);

// File: tb/byte_bank_port_bench.sv
`timescale 1ns/1ps
module byte_bank_port_bench;
  localparam int unsigned W = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus8_mode, req_valid, req_write, req_word;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        port_idle, rsp_done;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_en_even, mem_en_odd, mem_we;
  logic [15:0] mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] bmem [0:1023];

  always #2 clk = ~clk;

  byte_bank_port #(.WAIT_CYCLES(W)) u_byte_bank_port (
    .clk(clk), .rst_n(rst_n), .bus8_mode(bus8_mode), .req_valid(req_valid),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .port_idle(port_idle), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_en_even(mem_en_even),
    .mem_en_odd(mem_en_odd), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // memory model: flat byte array, indexed by the low address bits
  function automatic int ix(input logic [19:0] a);
    return int'(a[9:0]);
  endfunction

  always_comb begin
    if (bus8_mode) mem_rdata = {8'h00, bmem[ix(mem_addr)]};
    else mem_rdata = {bmem[ix({mem_addr[19:1], 1'b1})], bmem[ix({mem_addr[19:1], 1'b0})]};
  end

  always @(posedge clk) begin
    if (mem_we) begin
      if (bus8_mode) begin
        if (mem_en_even) bmem[ix(mem_addr)] <= mem_wdata[7:0];
      end else begin
        if (mem_en_even) bmem[ix({mem_addr[19:1], 1'b0})] <= mem_wdata[7:0];
        if (mem_en_odd)  bmem[ix({mem_addr[19:1], 1'b1})] <= mem_wdata[15:8];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // results of the last access
  logic [15:0] r_data;
  int          r_lat, r_active;
  logic [19:0] r_first, r_last;
  bit          r_even, r_odd, r_both;

  task automatic access(input logic m8, input logic wr, input logic wd,
                        input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    bus8_mode = m8; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 0; r_active = 0; r_even = 0; r_odd = 0; r_both = 0;
    while (!rsp_done && r_lat < 50) begin
      if (mem_en_even || mem_en_odd) begin
        if (r_active == 0) r_first = mem_addr;
        r_last = mem_addr;
        r_active++;
      end
      if (mem_en_even) r_even = 1;
      if (mem_en_odd)  r_odd = 1;
      if (mem_en_even && mem_en_odd) r_both = 1;
      @(posedge clk);
      r_lat++;
      @(negedge clk);
    end
    r_data = rsp_rdata;
    @(negedge clk);
    chk("R9", "done drops after one clock", {31'd0, rsp_done}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "idle", {31'd0, port_idle}, 32'd1);
    chk("R1", "done", {31'd0, rsp_done}, 32'd0);
    chk("R1", "enables/we", {29'd0, mem_en_even, mem_en_odd, mem_we}, 32'd0);
  endtask

  task automatic t_aligned_word();
    access(1'b0, 1'b1, 1'b1, 20'h00100, 16'h1234);
    chk("R2", "latency", r_lat, W + 1);
    chk("R2", "both banks", {31'd0, r_both}, 32'd1);
    chk("R2", "low byte", bmem[ix(20'h00100)], 8'h34);
    chk("R2", "high byte", bmem[ix(20'h00101)], 8'h12);
    access(1'b0, 1'b0, 1'b1, 20'h00100, 16'h0000);
    chk("R9", "aligned read data", r_data, 16'h1234);
  endtask

  task automatic t_odd_word();
    access(1'b0, 1'b1, 1'b1, 20'h00203, 16'hBEEF);
    chk("R3", "latency", r_lat, 2 * (W + 1));
    chk("R3", "first addr", r_first, 20'h00203);
    chk("R3", "second addr", r_last, 20'h00204);
    chk("R3", "never both", {31'd0, r_both}, 32'd0);
    chk("R3", "low byte", bmem[ix(20'h00203)], 8'hEF);
    chk("R3", "high byte", bmem[ix(20'h00204)], 8'hBE);
    access(1'b0, 1'b0, 1'b1, 20'h00203, 16'h0000);
    chk("R3", "split read data", r_data, 16'hBEEF);
  endtask

  task automatic t_bytes();
    logic [7:0] nb;
    nb = bmem[ix(20'h00301)];
    access(1'b0, 1'b1, 1'b0, 20'h00300, 16'h995A);
    chk("R4", "even only", {30'd0, r_even, r_odd}, 32'd2);
    chk("R4", "written", bmem[ix(20'h00300)], 8'h5A);
    chk("R4", "neighbour kept", bmem[ix(20'h00301)], nb);
    access(1'b0, 1'b1, 1'b0, 20'h00301, 16'h77C3);
    chk("R5", "odd only", {30'd0, r_even, r_odd}, 32'd1);
    chk("R5", "written", bmem[ix(20'h00301)], 8'hC3);
    chk("R5", "even kept", bmem[ix(20'h00300)], 8'h5A);
    access(1'b0, 1'b0, 1'b0, 20'h00301, 16'h0000);
    chk("R5", "odd byte read to low", r_data, 16'h00C3);
    access(1'b0, 1'b0, 1'b0, 20'h00300, 16'h0000);
    chk("R4", "even byte read", r_data, 16'h005A);
  endtask

  task automatic t_mode8();
    access(1'b1, 1'b1, 1'b1, 20'h00400, 16'h7788);
    chk("R6", "latency even word", r_lat, 2 * (W + 1));
    chk("R6", "single bank", {30'd0, r_even, r_odd}, 32'd2);
    chk("R6", "addr order", {r_first, 12'd0}, {20'h00400, 12'd0});
    chk("R6", "low byte", bmem[ix(20'h00400)], 8'h88);
    chk("R6", "high byte", bmem[ix(20'h00401)], 8'h77);
    access(1'b1, 1'b0, 1'b1, 20'h00400, 16'h0000);
    chk("R6", "word read", r_data, 16'h7788);
    access(1'b1, 1'b0, 1'b0, 20'h00401, 16'h0000);
    chk("R7", "latency byte", r_lat, W + 1);
    chk("R7", "byte read", r_data, 16'h0077);
    chk("R7", "single bank", {30'd0, r_even, r_odd}, 32'd2);
  endtask

  task automatic t_wrap();
    access(1'b0, 1'b1, 1'b1, 20'hFFFFF, 16'hA1B2);
    chk("R8", "first addr", r_first, 20'hFFFFF);
    chk("R8", "wrapped addr", r_last, 20'h00000);
    chk("R8", "low byte", bmem[ix(20'hFFFFF)], 8'hB2);
    chk("R8", "high byte", bmem[ix(20'h00000)], 8'hA1);
  endtask

  task automatic t_busy();
    logic [7:0] keep;
    int dones = 0;
    keep = bmem[ix(20'h00501)];
    @(negedge clk);
    bus8_mode = 1'b0; req_write = 1'b1; req_word = 1'b0;
    req_addr = 20'h00500; req_wdata = 16'h0011; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_addr = 20'h00501; req_wdata = 16'h0022;
    chk("R10", "busy while second request", {31'd0, port_idle}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (rsp_done) dones++;
      @(negedge clk);
    end
    chk("R10", "one completion", dones, 1);
    chk("R10", "first write", bmem[ix(20'h00500)], 8'h11);
    chk("R10", "ignored write", bmem[ix(20'h00501)], keep);
    chk("R10", "idle after", {31'd0, port_idle}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 8'(i) ^ 8'hA5;
  end

  initial begin
    rst_n = 1'b0;
    bus8_mode = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_aligned_word();
    t_odd_word();
    t_bytes();
    t_mode8();
    t_wrap();
    t_busy();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule